// File: doc/BRIEF.md
# DDS Tuning Command Register File

This block sits behind the serial front end of a direct digital synthesizer. It takes one 16-bit control word per accepted cycle and keeps the tuning state: two 32-bit frequency tuning words, four 12-bit phase offsets, a one-byte staging register, and the mode flags for load timing, selection source, power-down and accumulator reset. It then presents the frequency word and phase offset that are currently active.

Tuning words are loaded one 16-bit half at a time. A staging command parks one byte. A load command then writes that parked byte together with the byte it carries into the addressed half of a frequency or phase register. The active frequency and phase registers are chosen either by select bits that commands set, or by three external select pins. When the resynchronised mode is on, loads and the sampling of the selection both pass through two extra register stages, so they change together with two cycles of extra latency.

Top module: `dds_cmd_regfile`

## Requirements
- R1: While rst_ni is low, and after it rises with no command yet given, freq_o, phase_o, sync_o, selsrc_o, sleep_o and acc_clr_o are all zero. The stored select bits start at register 0.
- R2: Opcode word[15:12]=4'h3 (frequency staging) and opcode 4'h1 (phase staging) both write word[7:0] into the single shared staging byte. No output changes.
- R3: Opcode 4'h2 with address word[11:8] in 0..7 loads {word[7:0], staging byte} into frequency register address[2]. The lower half is written when address[1]=0 and the upper half when address[1]=1. Address[0] is ignored. With SYNC=0 the result is visible after the accepting clock edge.
- R4: Opcode 4'h0 with address in 8..15 loads {word[3:0], staging byte} into phase register address[2:1]. word[7:4] is ignored.
- R5: A frequency load with address[3]=1, a phase load with address[3]=0, and opcode 4'h7 change no tuning state.
- R6: Opcode 4'h4 stores word[10:9] as the phase select bits (word[9] is the LSB). Opcode 4'h5 stores word[11] as the frequency select bit. Opcode 4'h6 stores both. Fields that a command does not name keep their value.
- R7: With SELSRC=1 the stored select bits choose the active registers. With SELSRC=0, fsel_pin_i and psel_pin_i choose them. freq_o and phase_o show the chosen registers.
- R8: A word with word[15:14]=2'b10 sets SYNC from word[13] and SELSRC from word[12].
- R9: A word with word[15:14]=2'b11 sets SLEEP from word[13] and the accumulator reset flag from word[12]. word[11]=1 clears SYNC and SELSRC in the same write. The clear is not stored.
- R10: With SYNC=1, a load becomes visible two cycles later than with SYNC=0. A change of select pins or bits reaches the outputs only through two sampling stages.
- R11: A load accepted while SYNC=1 still commits after SYNC is cleared. If a direct load commits in the same cycle to the same half, the newer direct load wins. A load to the other half commits as well.
- R12: With cmd_valid_i low, no state changes, whatever word is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Control word is accepted on this edge |
| cmd_word_i | input | 16 | Control word |
| fsel_pin_i | input | 1 | External frequency register select |
| psel_pin_i | input | 2 | External phase register select |
| freq_o | output | 32 | Active frequency tuning word |
| phase_o | output | 12 | Active phase offset |
| fsel_o | output | 1 | Resolved frequency select |
| psel_o | output | 2 | Resolved phase select |
| sync_o | output | 1 | Resynchronised load mode |
| selsrc_o | output | 1 | Selection taken from stored bits |
| sleep_o | output | 1 | Power-down flag |
| acc_clr_o | output | 1 | Accumulator reset flag |

## Verification
Two commits can fall in the same cycle. One is a load still in the two-stage resynchronising path. The other is a direct load issued after a clear word has turned SYNC off. The bench provokes this with three back-to-back words: a load while SYNC=1, a clear, then a direct load. This is done once to the other half and once to the same half. It judges the outcome from the active frequency word: both halves must be updated in the first case, and only the newer data must appear in the second.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int HALF_W    = 2 * BYTE_W;
  localparam int FREQ_W    = 2 * HALF_W;
  localparam int PHASE_W   = 12;
  localparam int NUM_FREQ  = 2;
  localparam int NUM_PHASE = 4;
  localparam int FSEL_W    = $clog2(NUM_FREQ);
  localparam int PSEL_W    = $clog2(NUM_PHASE);
  localparam int SLOT_W    = PSEL_W;

  typedef enum logic [3:0] {
    OP_PH_LOAD  = 4'h0,
    OP_PH_STAGE = 4'h1,
    OP_FR_LOAD  = 4'h2,
    OP_FR_STAGE = 4'h3,
    OP_PSEL     = 4'h4,
    OP_FSEL     = 4'h5,
    OP_BOTHSEL  = 4'h6,
    OP_RSVD     = 4'h7
  } op_e;

  typedef struct packed {
    logic              vld;
    logic              is_phase;
    logic [SLOT_W-1:0] slot;   // freq: {reg, half}; phase: reg index
    logic [HALF_W-1:0] data;
  } wr_req_t;

  function automatic logic freq_hit(wr_req_t w, int idx);
    return w.vld && !w.is_phase && (int'(w.slot[1]) == idx);
  endfunction

  function automatic logic phase_hit(wr_req_t w, int idx);
    return w.vld && w.is_phase && (int'(w.slot) == idx);
  endfunction
endpackage

// File: rtl/dds_cmd_decode.sv
module dds_cmd_decode
  import dds_cmd_pkg::*;
(
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [BYTE_W-1:0] stage_i,
  output wr_req_t           wr_o,
  output logic              stage_we_o,
  output logic [BYTE_W-1:0] stage_d_o,
  output logic              psel_we_o,
  output logic [PSEL_W-1:0] psel_d_o,
  output logic              fsel_we_o,
  output logic [FSEL_W-1:0] fsel_d_o,
  output logic              mode_we_o,
  output logic              sync_d_o,
  output logic              selsrc_d_o,
  output logic              pwr_we_o,
  output logic              sleep_d_o,
  output logic              arst_d_o,
  output logic              clr_o
);
  op_e         op;
  logic [3:0]  addr;
  logic        is_ctl;
  logic        cmd_ok;

  assign op     = op_e'(word_i[15:12]);
  assign addr   = word_i[11:8];
  assign is_ctl = word_i[15];
  assign cmd_ok = valid_i && !is_ctl;

  always_comb begin
    wr_o          = '0;
    wr_o.is_phase = addr[3];
    wr_o.slot     = addr[2:1];
    wr_o.data     = {word_i[7:0], stage_i};
    wr_o.vld      = cmd_ok && (((op == OP_FR_LOAD) && !addr[3]) ||
                               ((op == OP_PH_LOAD) &&  addr[3]));
  end

  assign stage_we_o = cmd_ok && ((op == OP_FR_STAGE) || (op == OP_PH_STAGE));
  assign stage_d_o  = word_i[7:0];
  assign psel_we_o  = cmd_ok && ((op == OP_PSEL) || (op == OP_BOTHSEL));
  assign psel_d_o   = word_i[10:9];
  assign fsel_we_o  = cmd_ok && ((op == OP_FSEL) || (op == OP_BOTHSEL));
  assign fsel_d_o   = word_i[11];

  assign mode_we_o  = valid_i && (word_i[15:14] == 2'b10);
  assign sync_d_o   = word_i[13];
  assign selsrc_d_o = word_i[12];
  assign pwr_we_o   = valid_i && (word_i[15:14] == 2'b11);
  assign sleep_d_o  = word_i[13];
  assign arst_d_o   = word_i[12];
  assign clr_o      = word_i[11];
endmodule

// File: rtl/dds_tuning_bank.sv
module dds_tuning_bank
  import dds_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  wr_req_t            old_i,   // resynchronised port, older
  input  wr_req_t            new_i,   // direct port, newer, wins ties
  input  logic [FSEL_W-1:0]  fsel_i,
  input  logic [PSEL_W-1:0]  psel_i,
  output logic [FREQ_W-1:0]  freq_o,
  output logic [PHASE_W-1:0] phase_o
);
  logic [FREQ_W-1:0]  freq_arr  [NUM_FREQ];
  logic [PHASE_W-1:0] phase_arr [NUM_PHASE];

  for (genvar f = 0; f < NUM_FREQ; f++) begin : g_freq
    logic [FREQ_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else begin
        if (freq_hit(old_i, f)) begin
          if (old_i.slot[0]) q[FREQ_W-1:HALF_W] <= old_i.data;
          else               q[HALF_W-1:0]      <= old_i.data;
        end
        if (freq_hit(new_i, f)) begin
          if (new_i.slot[0]) q[FREQ_W-1:HALF_W] <= new_i.data;
          else               q[HALF_W-1:0]      <= new_i.data;
        end
      end
    end
    assign freq_arr[f] = q;
  end

  for (genvar p = 0; p < NUM_PHASE; p++) begin : g_phase
    logic [PHASE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else begin
        if (phase_hit(old_i, p)) q <= old_i.data[PHASE_W-1:0];
        if (phase_hit(new_i, p)) q <= new_i.data[PHASE_W-1:0];
      end
    end
    assign phase_arr[p] = q;
  end

  assign freq_o  = freq_arr[fsel_i];
  assign phase_o = phase_arr[psel_i];
endmodule

// File: rtl/dds_sel_path.sv
module dds_sel_path
  import dds_cmd_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              selsrc_i,
  input  logic [FSEL_W-1:0] fsel_bit_i,
  input  logic [PSEL_W-1:0] psel_bit_i,
  input  logic [FSEL_W-1:0] fsel_pin_i,
  input  logic [PSEL_W-1:0] psel_pin_i,
  output logic [FSEL_W-1:0] fsel_o,
  output logic [PSEL_W-1:0] psel_o
);
  localparam int SW = FSEL_W + PSEL_W;

  logic [SW-1:0] raw;
  logic [SW-1:0] sh [STAGES];
  logic [SW-1:0] sel;

  assign raw = selsrc_i ? {fsel_bit_i, psel_bit_i} : {fsel_pin_i, psel_pin_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sh[s] <= '0;
    end else begin
      sh[0] <= raw;
      for (int s = 1; s < STAGES; s++) sh[s] <= sh[s-1];
    end
  end

  assign sel    = sync_i ? sh[STAGES-1] : raw;
  assign fsel_o = sel[SW-1:PSEL_W];
  assign psel_o = sel[PSEL_W-1:0];
endmodule

// File: rtl/dds_cmd_regfile.sv
module dds_cmd_regfile
  import dds_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [WORD_W-1:0]  cmd_word_i,
  input  logic [FSEL_W-1:0]  fsel_pin_i,
  input  logic [PSEL_W-1:0]  psel_pin_i,
  output logic [FREQ_W-1:0]  freq_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [FSEL_W-1:0]  fsel_o,
  output logic [PSEL_W-1:0]  psel_o,
  output logic               sync_o,
  output logic               selsrc_o,
  output logic               sleep_o,
  output logic               acc_clr_o
);
  logic [BYTE_W-1:0] stage_q;
  logic              sync_q, selsrc_q, sleep_q, arst_q;
  logic [FSEL_W-1:0] fbit_q;
  logic [PSEL_W-1:0] pbit_q;

  wr_req_t           dec_wr, feed_wr, direct_wr;
  logic              stage_we, psel_we, fsel_we, mode_we, pwr_we;
  logic [BYTE_W-1:0] stage_d;
  logic [PSEL_W-1:0] psel_d;
  logic [FSEL_W-1:0] fsel_d;
  logic              sync_d, selsrc_d, sleep_d, arst_d, clr;

  dds_cmd_decode u_dec (
    .valid_i    (cmd_valid_i),
    .word_i     (cmd_word_i),
    .stage_i    (stage_q),
    .wr_o       (dec_wr),
    .stage_we_o (stage_we),
    .stage_d_o  (stage_d),
    .psel_we_o  (psel_we),
    .psel_d_o   (psel_d),
    .fsel_we_o  (fsel_we),
    .fsel_d_o   (fsel_d),
    .mode_we_o  (mode_we),
    .sync_d_o   (sync_d),
    .selsrc_d_o (selsrc_d),
    .pwr_we_o   (pwr_we),
    .sleep_d_o  (sleep_d),
    .arst_d_o   (arst_d),
    .clr_o      (clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      sync_q   <= 1'b0;
      selsrc_q <= 1'b0;
      sleep_q  <= 1'b0;
      arst_q   <= 1'b0;
      fbit_q   <= '0;
      pbit_q   <= '0;
    end else begin
      if (stage_we) stage_q <= stage_d;
      if (psel_we)  pbit_q  <= psel_d;
      if (fsel_we)  fbit_q  <= fsel_d;
      if (mode_we) begin
        sync_q   <= sync_d;
        selsrc_q <= selsrc_d;
      end
      if (pwr_we) begin
        sleep_q <= sleep_d;
        arst_q  <= arst_d;
        if (clr) begin
          sync_q   <= 1'b0;
          selsrc_q <= 1'b0;
        end
      end
    end
  end

  // split each load between the direct port and the resync pipe
  always_comb begin
    feed_wr       = dec_wr;
    feed_wr.vld   = dec_wr.vld && sync_q;
    direct_wr     = dec_wr;
    direct_wr.vld = dec_wr.vld && !sync_q;
  end

  wr_req_t wpipe [SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) wpipe[s] <= '0;
    end else begin
      wpipe[0] <= feed_wr;
      for (int s = 1; s < SYNC_STAGES; s++) wpipe[s] <= wpipe[s-1];
    end
  end

  logic [FSEL_W-1:0] fsel_act;
  logic [PSEL_W-1:0] psel_act;

  dds_sel_path #(.STAGES(SYNC_STAGES)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_q),
    .selsrc_i   (selsrc_q),
    .fsel_bit_i (fbit_q),
    .psel_bit_i (pbit_q),
    .fsel_pin_i (fsel_pin_i),
    .psel_pin_i (psel_pin_i),
    .fsel_o     (fsel_act),
    .psel_o     (psel_act)
  );

  dds_tuning_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .old_i   (wpipe[SYNC_STAGES-1]),
    .new_i   (direct_wr),
    .fsel_i  (fsel_act),
    .psel_i  (psel_act),
    .freq_o  (freq_o),
    .phase_o (phase_o)
  );

  assign fsel_o    = fsel_act;
  assign psel_o    = psel_act;
  assign sync_o    = sync_q;
  assign selsrc_o  = selsrc_q;
  assign sleep_o   = sleep_q;
  assign acc_clr_o = arst_q;
endmodule

// File: rtl/dds_cmd_regfile_chk.sv
module dds_cmd_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [15:0] cmd_word_i,
  input logic [0:0]  fsel_pin_i,
  input logic [1:0]  psel_pin_i,
  input logic [31:0] freq_o,
  input logic [11:0] phase_o,
  input logic [0:0]  fsel_o,
  input logic [1:0]  psel_o,
  input logic        sync_o,
  input logic        selsrc_o,
  input logic        sleep_o,
  input logic        acc_clr_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;

  always @(posedge clk_i)
    if (!rst_ni) begin
      p_reset_r1: assert (freq_o == '0 && phase_o == '0 && !sync_o && !selsrc_o &&
                          !sleep_o && !acc_clr_o)
        else $error("reset values");
    end

  p_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_word_i[15:14] == 2'b10 |=>
      sync_o == $past(cmd_word_i[13]) && selsrc_o == $past(cmd_word_i[12]));

  p_pwr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_word_i[15:14] == 2'b11 |=>
      sleep_o == $past(cmd_word_i[13]) && acc_clr_o == $past(cmd_word_i[12]));

  p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_word_i[15:14] == 2'b11 && cmd_word_i[11] |=> !sync_o && !selsrc_o);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(sync_o) && $stable(selsrc_o) && $stable(sleep_o) &&
                     $stable(acc_clr_o));

  p_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_o && !selsrc_o |-> fsel_o == fsel_pin_i && psel_o == psel_pin_i);

  p_pin_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q == 2'd3 && sync_o && !$past(selsrc_o, 2) |->
      fsel_o == $past(fsel_pin_i, 2) && psel_o == $past(psel_pin_i, 2));
endmodule

bind dds_cmd_regfile dds_cmd_regfile_chk u_chk (.*);

// File: tb/dds_cmd_regfile_test.sv
`timescale 1ns/1ps
module dds_cmd_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [0:0]  fsel_pin = '0;
  logic [1:0]  psel_pin = '0;
  logic [31:0] freq_o;
  logic [11:0] phase_o;
  logic [0:0]  fsel_o;
  logic [1:0]  psel_o;
  logic        sync_o, selsrc_o, sleep_o, acc_clr_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dds_cmd_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .fsel_pin_i(fsel_pin), .psel_pin_i(psel_pin), .freq_o(freq_o), .phase_o(phase_o),
    .fsel_o(fsel_o), .psel_o(psel_o), .sync_o(sync_o), .selsrc_o(selsrc_o),
    .sleep_o(sleep_o), .acc_clr_o(acc_clr_o)
  );

  typedef struct packed {
    logic [15:0] w;
    logic        fp;
    logic [1:0]  pp;
    logic [31:0] ef;
    logic [11:0] ep;
    logic [3:0]  fl;   // {sync, selsrc, sleep, acc_clr}
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{16'h3078, 1'b0, 2'd0, 32'h00000000, 12'h000, 4'h0}, // R2 stage
    '{16'h2156, 1'b0, 2'd0, 32'h00005678, 12'h000, 4'h0}, // R3 low half
    '{16'h3234, 1'b0, 2'd0, 32'h00005678, 12'h000, 4'h0}, // R2
    '{16'h2312, 1'b0, 2'd0, 32'h12345678, 12'h000, 4'h0}, // R3 high half
    '{16'h10BC, 1'b0, 2'd0, 32'h12345678, 12'h000, 4'h0}, // R2 phase stage
    '{16'h09FA, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}, // R4 top nibble dropped
    '{16'h2999, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}, // R5 freq op, phase addr
    '{16'h0177, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}, // R5 phase op, freq addr
    '{16'h70FF, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}, // R5 reserved
    '{16'h30EF, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}, // R2
    '{16'h25CD, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}, // R3 freq1 hidden
    '{16'h3001, 1'b1, 2'd0, 32'h0000CDEF, 12'hABC, 4'h0}, // R7 pin picks freq1
    '{16'h1021, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}, // R2
    '{16'h0D03, 1'b0, 2'd2, 32'h12345678, 12'h321, 4'h0}, // R4 phase2, R7 pin
    '{16'h6E00, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}, // R6 bits set, pins rule
    '{16'h9000, 1'b0, 2'd0, 32'h0000CDEF, 12'h000, 4'h4}, // R8 selsrc on
    '{16'h5000, 1'b0, 2'd0, 32'h12345678, 12'h000, 4'h4}, // R6 fsel only
    '{16'h4400, 1'b0, 2'd0, 32'h12345678, 12'h321, 4'h4}, // R6 psel=2
    '{16'h4200, 1'b0, 2'd0, 32'h12345678, 12'h000, 4'h4}, // R6 psel=1
    '{16'hC800, 1'b1, 2'd2, 32'h0000CDEF, 12'h321, 4'h0}, // R9 clear
    '{16'hF000, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h3}, // R9 sleep, acc reset
    '{16'hC000, 1'b0, 2'd0, 32'h12345678, 12'hABC, 4'h0}  // R9
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic burst3(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2);
    @(negedge clk); cmd_valid = 1'b1; cmd_word = w0;
    @(negedge clk); cmd_word = w1;
    @(negedge clk); cmd_word = w2;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  function automatic logic [3:0] flags();
    return {sync_o, selsrc_o, sleep_o, acc_clr_o};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {freq_o, phase_o, flags()}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", {freq_o, phase_o, flags(), fsel_o, psel_o}, '0);

    for (int i = 0; i < NV; i++) begin
      fsel_pin = VECS[i].fp;
      psel_pin = VECS[i].pp;
      send(VECS[i].w);
      check($sformatf("table row %0d", i), {freq_o, phase_o, flags()},
            {VECS[i].ef, VECS[i].ep, VECS[i].fl});
    end
    fsel_pin = '0;
    psel_pin = '0;

    // R12: a word without valid does nothing
    @(negedge clk);
    cmd_word = 16'hF000;
    @(negedge clk);
    cmd_word = 16'h2377;
    @(negedge clk);
    check("R12 idle word", {freq_o, phase_o, flags()}, {32'h12345678, 12'hABC, 4'h0});

    // R10: resynchronised load latency
    send(16'hA000);
    check("R8 sync on", flags(), 4'h8);
    send(16'h30AA);
    send(16'h21BB);
    check("R10 load edge+0", freq_o, 32'h12345678);
    @(negedge clk);
    check("R10 load edge+1", freq_o, 32'h12345678);
    @(negedge clk);
    check("R10 load edge+2", freq_o, 32'h1234BBAA);

    // R10: pin sampling through two stages
    fsel_pin = 1'b1;
    @(negedge clk);
    check("R10 pin edge+0", freq_o, 32'h1234BBAA);
    @(negedge clk);
    check("R10 pin edge+1", freq_o, 32'h0000CDEF);
    fsel_pin = 1'b0;
    repeat (3) @(negedge clk);

    // R11: in-flight resync load and a direct load, different halves
    send(16'h3011);
    burst3(16'h2322, 16'hC800, 16'h2155);
    check("R11 both halves", {freq_o, 3'b000, sync_o}, {32'h22115511, 4'h0});

    // R11: same half, newer direct load wins
    send(16'hA000);
    burst3(16'h2366, 16'hC800, 16'h2377);
    check("R11 newer wins", {freq_o, 3'b000, sync_o}, {32'h77115511, 4'h0});
    @(negedge clk);
    check("R11 settled", freq_o, 32'h77115511);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule